// File: doc/BRIEF.md
# Serial Controller Reset Sequencer

This block produces the internal reset signals for a two-channel serial controller's write-register file. It recognises a hardware reset from a bus condition that is otherwise illegal: the active-low address strobe and the active-low data strobe are both low at once. It also decodes software reset commands written into a shared master control register. Each reset is held past the end of its cause by a fixed stretch. While a reset or its stretch is active, bus accesses are dropped.

A small write-register model is included so that reset values can be read back. Each channel has `N_CREG` eight-bit control registers, and the two channels share one master register. A single-cycle access port carries a channel select, a register index, write data and a registered read return. The two strobes reach the block through a two-flop synchronizer, and the both-low condition is evaluated on the synchronized values.

Top module: `scc_reset_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `dev_rst`, `chan_a_rst`, `chan_b_rst` and `rd_valid` are low, and every register reads back as zero afterwards.
- R2: When `as_n` and `ds_n` are both driven low, `busy` and `dev_rst` are low after the second rising edge and high after the third. Holding only one strobe low never raises `busy`.
- R3: After both strobes return high, `busy` and `dev_rst` stay high until the 7th rising edge, which is 2 synchronizer cycles plus a stretch of 5. Sampled between edges, that is 6 high samples.
- R4: While `busy` is high, or while the synchronized both-low condition holds, writes change no register, and reads give `rd_valid` low the next cycle.
- R5: A write of command 01 to bits [7:6] of the master register (index 4) raises `chan_b_rst` for 5 cycles. It leaves `chan_a_rst` and `dev_rst` low and channel A's registers unchanged.
- R6: Command 10 raises `chan_a_rst` for 5 cycles and affects only channel A.
- R7: Command 11 raises `dev_rst`, `chan_a_rst` and `chan_b_rst` for 5 cycles and clears every channel register to zero. Master bits [5:0] take the value written in that same write.
- R8: A hardware reset clears master bits [5:0] to zero and clears every channel register.
- R9: A channel reset keeps the bits selected by the per-register keep mask (register 0: 0x00, register 1: 0x24, register 2: 0xFF, register 3: 0x0C) and clears all other bits of that channel's registers.
- R10: Command bits are not stored: the master register reads back with bits [7:6] equal to 00. Command 00 causes no reset.
- R11: A hardware reset condition that reappears during a stretch restarts the stretch, so `busy` falls 7 edges after the final release.
- R12: An accepted read returns `rd_valid` high with the register value one cycle later. Channel registers use `acc_chan` 1 for A and 0 for B. Indices 5 to 7 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_chan | input | 1 | 1 = channel A, 0 = channel B |
| acc_reg | input | 3 | Register index; 0..3 channel, 4 master |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data returned |
| busy | output | 1 | Any reset or stretch active |
| dev_rst | output | 1 | Device-wide reset |
| chan_a_rst | output | 1 | Channel A reset |
| chan_b_rst | output | 1 | Channel B reset |

## Verification
The hardest case to reach is a hardware reset condition that reappears while an earlier stretch is still counting down. It has to be timed against the synchronizer delay, because the restart must extend the stretch rather than add to it. The bench releases the strobes, waits a few cycles inside the stretch, pulls them low again and then measures `busy` from the second release. It also attempts a write and a read in the first cycles of a stretch, to show that they are dropped. Random traffic mixes in channel and full software reset commands and periodic hardware resets, and a bench model checks the keep masks and master bits against read-back.

// File: rtl/scc_reset_seq.sv
module scc_reset_seq #(
  parameter int N_CREG = 4,
  parameter int STRETCH = 5,
  parameter logic [N_CREG*8-1:0] CH_KEEP = 32'h0C_FF_24_00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       ds_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_chan,
  input  logic [$clog2(N_CREG+1)-1:0] acc_reg,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic       busy,
  output logic       dev_rst,
  output logic       chan_a_rst,
  output logic       chan_b_rst
);
  localparam int AW = $clog2(N_CREG+1);
  localparam int CW = $clog2(STRETCH+1);
  localparam logic [AW-1:0] MIDX = AW'(N_CREG);
  localparam logic [CW-1:0] CLOAD = CW'(STRETCH);

  logic [1:0] as_sy, ds_sy;
  logic [CW-1:0] dev_cnt, a_cnt, b_cnt;
  logic [7:0] creg [2][N_CREG];
  logic [5:0] mstr;
  logic [7:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_sy <= 2'b11;
      ds_sy <= 2'b11;
    end else begin
      as_sy <= {as_sy[0], as_n};
      ds_sy <= {ds_sy[0], ds_n};
    end

  wire hw_cond  = ~as_sy[1] & ~ds_sy[1];
  wire acc_ok   = acc_valid & ~busy & ~hw_cond;
  wire wr_ok    = acc_ok & acc_write;
  wire rd_ok    = acc_ok & ~acc_write;
  wire mwr      = wr_ok & (acc_reg == MIDX);
  wire [1:0] cmd = mwr ? wdata[7:6] : 2'b00;
  wire full_req = hw_cond | (cmd == 2'b11);
  wire [1:0] ch_req = full_req ? 2'b00 : {cmd == 2'b10, cmd == 2'b01};

  function automatic logic [CW-1:0] step(input logic ld, input logic [CW-1:0] c);
    if (ld) return CLOAD;
    if (c != '0) return c - CW'(1);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dev_cnt <= '0;
      a_cnt   <= '0;
      b_cnt   <= '0;
    end else begin
      dev_cnt <= step(full_req, dev_cnt);
      a_cnt   <= step(ch_req[1], a_cnt);
      b_cnt   <= step(ch_req[0], b_cnt);
    end

  assign dev_rst    = dev_cnt != '0;
  assign chan_a_rst = dev_rst | (a_cnt != '0);
  assign chan_b_rst = dev_rst | (b_cnt != '0);
  assign busy       = chan_a_rst | chan_b_rst;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    for (genvar r = 0; r < N_CREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          creg[ch][r] <= '0;
        else if (full_req)
          creg[ch][r] <= '0;
        else if (ch_req[ch])
          creg[ch][r] <= creg[ch][r] & CH_KEEP[r*8 +: 8];
        else if (wr_ok && (acc_chan == (ch == 1)) && acc_reg == AW'(r))
          creg[ch][r] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mstr <= '0;
    else if (hw_cond) mstr <= '0;
    else if (mwr)     mstr <= wdata[5:0];

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < N_CREG; r++)
      if (acc_reg == AW'(r)) rd_mux = acc_chan ? creg[1][r] : creg[0][r];
    if (acc_reg == MIDX) rd_mux = {2'b00, mstr};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_ok;
      rdata    <= rd_ok ? rd_mux : '0;
    end
endmodule

// File: rtl/scc_reset_seq_chk.sv
module scc_reset_seq_chk #(
  parameter int AW = 3,
  parameter int N_CREG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_reg,
  input logic [7:0]    rdata,
  input logic          rd_valid,
  input logic          busy,
  input logic          dev_rst,
  input logic          chan_a_rst,
  input logic          chan_b_rst
);
  AST_DEV_COVERS_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n) dev_rst |-> (chan_a_rst && chan_b_rst)); // R7
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_rst) |=> dev_rst); // R3
  AST_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (busy && acc_valid && !acc_write) |=> !rd_valid); // R4
  AST_READ_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(acc_valid && !acc_write)); // R12
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(acc_reg) == AW'(N_CREG)) |-> rdata[7:6] == 2'b00); // R10
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) !dev_rst |-> !(chan_a_rst && chan_b_rst)); // R5
endmodule

bind scc_reset_seq scc_reset_seq_chk #(.AW(AW), .N_CREG(N_CREG)) u_chk (.*);

// File: tb/tb_scc_reset_seq.sv
module tb_scc_reset_seq;
  logic clk = 0, rst_n = 0, as_n = 1, ds_n = 1;
  logic acc_valid = 0, acc_write = 0, acc_chan = 0;
  logic [2:0] acc_reg = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rd_valid, busy, dev_rst, chan_a_rst, chan_b_rst;
  int total = 0, bad = 0;
  logic [7:0] m_c [2][4];
  logic [5:0] m_m;

  always #10 clk = ~clk;

  scc_reset_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] keep_of(input int r);
    case (r)
      1: return 8'h24;
      2: return 8'hFF;
      3: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input bit ch, input int r);
    if (r < 4) return m_c[ch][r];
    if (r == 4) return {2'b00, m_m};
    return 8'h00;
  endfunction

  task automatic model_clear(input bit hw, input logic [5:0] mnew);
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) m_c[c][r] = 0;
    m_m = hw ? 6'd0 : mnew;
  endtask

  task automatic do_write(input bit ch, input int r, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_chan = ch; acc_reg = 3'(r); wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic do_read(input bit ch, input int r, output logic v, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_chan = ch; acc_reg = 3'(r);
    @(negedge clk);
    acc_valid = 0;
    v = rd_valid; d = rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 60) begin n++; @(negedge clk); end
  endtask

  task automatic hw_pulse(input int hold, output int n);
    @(negedge clk); as_n = 0; ds_n = 0;
    repeat (hold) @(negedge clk);
    as_n = 1; ds_n = 1;
    @(negedge clk);
    busy_len(n);
  endtask

  task automatic check_all(input string req);
    logic v; logic [7:0] d;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 5; r++) begin
        do_read(c[0], r, v, d);
        chk(v && d == exp_read(c[0], r), req, d, exp_read(c[0], r));
      end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic v;
    logic [7:0] d;
    void'($urandom(32'd2417));
    model_clear(1, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !dev_rst && !chan_a_rst && !chan_b_rst && !rd_valid, "R1", busy, 0);
    rst_n = 1;
    check_all("R1");

    // R2 one strobe only
    @(negedge clk); as_n = 0;
    repeat (6) begin @(negedge clk); chk(!busy, "R2 single strobe", busy, 0); end
    as_n = 1;
    // R2 rise timing
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) begin
      m_c[c][r] = 8'($urandom); do_write(c[0], r, m_c[c][r]);
    end
    do_write(0, 4, 8'h2A); m_m = 6'h2A;
    @(negedge clk); as_n = 0; ds_n = 0;
    @(negedge clk); @(negedge clk);
    chk(!busy, "R2 before third edge", busy, 0);
    @(negedge clk);
    chk(busy && dev_rst, "R2 after third edge", busy, 1);
    @(negedge clk); as_n = 1; ds_n = 1;
    @(negedge clk); busy_len(n);
    chk(n == 6, "R3 stretch length", n, 6);
    model_clear(1, 0);
    check_all("R8");

    // R4 access during stretch
    @(negedge clk); as_n = 0; ds_n = 0;
    repeat (4) @(negedge clk);
    as_n = 1; ds_n = 1;
    acc_valid = 1; acc_write = 1; acc_chan = 1; acc_reg = 0; wdata = 8'h5A;
    @(negedge clk);
    acc_write = 0;
    @(negedge clk);
    acc_valid = 0;
    chk(!rd_valid, "R4 read dropped", rd_valid, 0);
    busy_len(n);
    do_read(1, 0, v, d);
    chk(v && d == 8'h00, "R4 write dropped", d, 0);

    // R11 restart
    @(negedge clk); as_n = 0; ds_n = 0;
    repeat (4) @(negedge clk);
    as_n = 1; ds_n = 1;
    repeat (3) @(negedge clk);
    chk(busy, "R11 inside stretch", busy, 1);
    as_n = 0; ds_n = 0;
    repeat (4) @(negedge clk);
    as_n = 1; ds_n = 1;
    @(negedge clk); busy_len(n);
    chk(n == 6, "R11 restarted length", n, 6);

    // R6 and R9 channel A reset
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) begin
      m_c[c][r] = 8'hFF; do_write(c[0], r, 8'hFF);
    end
    do_write(0, 4, 8'h80 | 8'h15);
    chk(chan_a_rst && !chan_b_rst && !dev_rst, "R6 outputs", {chan_a_rst, chan_b_rst, dev_rst}, 3'b100);
    busy_len(n);
    chk(n == 5, "R6 length", n, 5);
    m_m = 6'h15;
    for (int r = 0; r < 4; r++) m_c[1][r] = m_c[1][r] & keep_of(r);
    check_all("R9");

    // R5 channel B reset
    do_write(0, 4, 8'h40 | 8'h09);
    chk(!chan_a_rst && chan_b_rst && !dev_rst, "R5 outputs", {chan_a_rst, chan_b_rst, dev_rst}, 3'b010);
    busy_len(n);
    chk(n == 5, "R5 length", n, 5);
    m_m = 6'h09;
    for (int r = 0; r < 4; r++) m_c[0][r] = m_c[0][r] & keep_of(r);
    check_all("R5");

    // R7 full software reset
    do_write(1, 4, 8'hC0 | 8'h33);
    chk(chan_a_rst && chan_b_rst && dev_rst, "R7 outputs", {chan_a_rst, chan_b_rst, dev_rst}, 3'b111);
    busy_len(n);
    chk(n == 5, "R7 length", n, 5);
    model_clear(0, 6'h33);
    check_all("R7");

    // R10 command 00 and read-back
    do_write(0, 4, 8'h3C);
    chk(!busy, "R10 no reset", busy, 0);
    m_m = 6'h3C;
    do_read(0, 4, v, d);
    chk(v && d == 8'h3C, "R10 command not stored", d, 8'h3C);

    // R12 unused indices
    do_write(1, 6, 8'hEE);
    do_read(1, 6, v, d);
    chk(v && d == 8'h00, "R12 unused index", d, 0);
    check_all("R12");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      bit ch; int r, op;
      logic [7:0] dd;
      ch = 1'($urandom); r = int'($urandom % 8); op = int'($urandom % 4);
      dd = 8'($urandom);
      if (i % 150 == 149) begin
        hw_pulse(3 + int'($urandom % 4), n);
        chk(n == 6, "R3 random hw", n, 6);
        model_clear(1, 0);
      end else if (op < 2) begin
        if (r == 4 && ($urandom % 4) != 0) dd[7:6] = 2'b00;
        do_write(ch, r, dd);
        if (r == 4) begin
          m_m = dd[5:0];
          if (dd[7:6] != 2'b00) begin
            busy_len(n);
            chk(n == 5, "R5 R6 R7 random command", n, 5);
            if (dd[7:6] == 2'b11) model_clear(0, dd[5:0]);
            else for (int q = 0; q < 4; q++)
              m_c[dd[7]][q] = m_c[dd[7]][q] & keep_of(q);
          end
        end else if (r < 4) m_c[ch][r] = dd;
      end else begin
        do_read(ch, r, v, d);
        chk(v && d == exp_read(ch, r), "R12 random read", d, exp_read(ch, r));
      end
    end
    check_all("R12 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule